// File: doc/BRIEF.md
# Gigabit Double-Data-Rate Pin Adapter

This block sits between a MAC that works with whole bytes per clock and a PHY link that carries only four data lines and one control line in each direction. On the outbound path it takes a byte together with an enable flag and an error flag on every rising clock edge. During the high phase of the next cycle it places the low nibble and the enable flag on the pins. During the low phase it places the high nibble and the control value (enable XOR error). At 125 MHz this keeps the full gigabit byte rate on half the data lines.

The inbound path does the reverse. It latches the first-half nibble and control bit at the falling edge. At the following rising edge it joins them with the second-half values into a byte, a data-valid flag and an error flag. All double-rate behaviour is built from plain flip-flops clocked on both edges, with no device-specific cells. Clock skew or delay lines, slower line rates and frame handling belong to neighbouring blocks.

Top module: `rgmii_ddr_adapter`

## Requirements
- R1: While reset is low, the outbound data and control pins and the inbound byte, valid and error outputs are all 0, whatever the byte-side inputs are.
- R2: Bits 3:0 of a byte sampled at rising edge k appear on the outbound data pins during the high phase that follows edge k.
- R3: Bits 7:4 of that byte appear on the outbound data pins during the low phase of the same cycle, until edge k+1.
- R4: During the high phase after edge k, the outbound control pin equals the enable flag sampled at edge k.
- R5: During the low phase, the outbound control pin equals enable XOR error. With enable and error both 0, the control pin is low in both halves.
- R6: The inbound nibble present at a falling edge becomes bits 3:0, and the inbound nibble present at the next rising edge becomes bits 7:4, of the byte shown right after that rising edge (one cycle of latency).
- R7: The inbound valid output equals the control bit taken at the falling edge. The inbound error output equals that bit XOR the control bit taken at the next rising edge.
- R8: With the outbound pins wired to the inbound pins, every byte, enable and error value sampled at edge k comes out unchanged on the inbound outputs right after edge k+1.
- R9: Byte data is carried through unchanged even when enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock, 125 MHz at gigabit rate; both edges are used |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_data | input | 8 | Outbound byte from the MAC side |
| tx_en | input | 1 | Outbound enable flag |
| tx_err | input | 1 | Outbound error flag |
| rgm_txd | output | 4 | Outbound nibble lines, double data rate |
| rgm_txctl | output | 1 | Outbound control line, double data rate |
| rgm_rxd | input | 4 | Inbound nibble lines, double data rate |
| rgm_rxctl | input | 1 | Inbound control line, double data rate |
| rx_data | output | 8 | Rebuilt inbound byte |
| rx_dv | output | 1 | Rebuilt inbound valid flag |
| rx_err | output | 1 | Rebuilt inbound error flag |

## Verification
Outbound pin values for a byte sampled at edge k are due within that same cycle: the first half is read a quarter period after edge k, and the second half three quarters after it. Inbound outputs for pin values presented during cycle k are due just after edge k+1, so with the pins looped back a byte returns exactly one cycle after it was sampled. The reference queue holds each stimulus record. At every rising edge the bench takes the newest record as the outbound expectation and the one before it as the inbound expectation. Every comparison is made a quarter cycle away from any edge.

// File: rtl/rgmii_ddr_pkg.sv
`timescale 1ns/1ps
package rgmii_ddr_pkg;

    // default nibble width of the double-rate pin group
    localparam int unsigned NIB_W_DEF = 4;

    // second-half control value: enable XOR error keeps an idle line low
    function automatic logic ctl_encode_fall(input logic en, input logic err);
        return en ^ err;
    endfunction

    // recover the error flag from the two halves of the control line
    function automatic logic ctl_decode_err(input logic ctl_rise, input logic ctl_fall);
        return ctl_rise ^ ctl_fall;
    endfunction

endpackage

// File: rtl/rgmii_ddr_out_cell.sv
`timescale 1ns/1ps
// One double-rate output bit built from two edge flops whose XOR drives the pin.
// Only one of the two flops changes at each edge, so the pin cannot glitch.
module rgmii_ddr_out_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_bit,   // value for the high phase, sampled at the rising edge
    input  logic fall_bit,   // value for the low phase, sampled at the rising edge
    output logic pin_q
);
    typedef struct packed {
        logic lead;   // posedge term of the XOR pair
        logic hold;   // low-phase value held for the falling edge
    } pos_st_t;

    pos_st_t pos_d, pos_q;
    logic    neg_d, neg_q;

    always_comb begin
        pos_d      = pos_q;
        pos_d.lead = rise_bit ^ neg_q;
        pos_d.hold = fall_bit;
        neg_d      = pos_q.hold ^ pos_q.lead;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= neg_d;
    end

    assign pin_q = pos_q.lead ^ neg_q;
endmodule

// File: rtl/rgmii_tx_ddr.sv
`timescale 1ns/1ps
// Outbound path: splits a byte plus flags into two half-cycle lane words.
module rgmii_tx_ddr #(
    parameter int unsigned NIB_W = rgmii_ddr_pkg::NIB_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*NIB_W-1:0]   byte_i,
    input  logic                 en_i,
    input  logic                 err_i,
    output logic [NIB_W-1:0]     txd_o,
    output logic                 txctl_o
);
    localparam int unsigned LANES = NIB_W + 1;   // data lanes plus control lane

    logic [LANES-1:0] rise_word;
    logic [LANES-1:0] fall_word;
    logic [LANES-1:0] pin_word;

    always_comb begin
        rise_word = {en_i, byte_i[NIB_W-1:0]};
        fall_word = {rgmii_ddr_pkg::ctl_encode_fall(en_i, err_i), byte_i[2*NIB_W-1:NIB_W]};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rgmii_ddr_out_cell i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise_bit (rise_word[g]),
            .fall_bit (fall_word[g]),
            .pin_q    (pin_word[g])
        );
    end

    assign txd_o   = pin_word[NIB_W-1:0];
    assign txctl_o = pin_word[LANES-1];
endmodule

// File: rtl/rgmii_rx_ddr.sv
`timescale 1ns/1ps
// Inbound path: falling edge keeps the first half, rising edge joins both halves.
module rgmii_rx_ddr #(
    parameter int unsigned NIB_W = rgmii_ddr_pkg::NIB_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NIB_W-1:0]     rxd_i,
    input  logic                 rxctl_i,
    output logic [2*NIB_W-1:0]   byte_o,
    output logic                 dv_o,
    output logic                 err_o
);
    localparam int unsigned BYTE_W = 2 * NIB_W;

    typedef struct packed {
        logic [NIB_W-1:0] lo;
        logic             ctl;
    } half_st_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              dv;
        logic              err;
    } out_st_t;

    half_st_t half_d, half_q;
    out_st_t  out_d,  out_q;

    always_comb begin
        half_d     = half_q;
        half_d.lo  = rxd_i;
        half_d.ctl = rxctl_i;

        out_d      = out_q;
        out_d.data = {rxd_i, half_q.lo};
        out_d.dv   = half_q.ctl;
        out_d.err  = rgmii_ddr_pkg::ctl_decode_err(half_q.ctl, rxctl_i);
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) half_q <= '0;
        else        half_q <= half_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign byte_o = out_q.data;
    assign dv_o   = out_q.dv;
    assign err_o  = out_q.err;
endmodule

// File: rtl/rgmii_ddr_adapter.sv
`timescale 1ns/1ps
module rgmii_ddr_adapter #(
    parameter int unsigned NIB_W = rgmii_ddr_pkg::NIB_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*NIB_W-1:0]   tx_data,
    input  logic                 tx_en,
    input  logic                 tx_err,
    output logic [NIB_W-1:0]     rgm_txd,
    output logic                 rgm_txctl,
    input  logic [NIB_W-1:0]     rgm_rxd,
    input  logic                 rgm_rxctl,
    output logic [2*NIB_W-1:0]   rx_data,
    output logic                 rx_dv,
    output logic                 rx_err
);
    rgmii_tx_ddr #(.NIB_W(NIB_W)) i_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_i  (tx_data),
        .en_i    (tx_en),
        .err_i   (tx_err),
        .txd_o   (rgm_txd),
        .txctl_o (rgm_txctl)
    );

    rgmii_rx_ddr #(.NIB_W(NIB_W)) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd_i   (rgm_rxd),
        .rxctl_i (rgm_rxctl),
        .byte_o  (rx_data),
        .dv_o    (rx_dv),
        .err_o   (rx_err)
    );
endmodule

// File: rtl/rgmii_ddr_adapter_chk.sv
`timescale 1ns/1ps
module rgmii_ddr_adapter_chk #(
    parameter int unsigned NIB_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2*NIB_W-1:0]   tx_data,
    input logic                 tx_en,
    input logic                 tx_err,
    input logic [NIB_W-1:0]     rgm_txd,
    input logic                 rgm_txctl,
    input logic [NIB_W-1:0]     rgm_rxd,
    input logic                 rgm_rxctl,
    input logic [2*NIB_W-1:0]   rx_data,
    input logic                 rx_dv,
    input logic                 rx_err
);
    // pin values seen during each high phase, taken at the falling edge
    logic [NIB_W-1:0] hp_txd, hp_rxd;
    logic             hp_txctl, hp_rxctl;
    logic [1:0]       arm_q;
    logic             armed;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hp_txd   <= '0;
            hp_txctl <= 1'b0;
            hp_rxd   <= '0;
            hp_rxctl <= 1'b0;
        end else begin
            hp_txd   <= rgm_txd;
            hp_txctl <= rgm_txctl;
            hp_rxd   <= rgm_rxd;
            hp_rxctl <= rgm_rxctl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             arm_q <= 2'd0;
        else if (arm_q != 2'd2) arm_q <= arm_q + 2'd1;
    end
    assign armed = (arm_q == 2'd2);

    // R2
    tx_lo_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> hp_txd == $past(tx_data[NIB_W-1:0]));
    // R3
    tx_hi_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> rgm_txd == $past(tx_data[2*NIB_W-1:NIB_W]));
    // R4
    tx_ctl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> hp_txctl == $past(tx_en));
    // R5
    tx_ctl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> rgm_txctl == ($past(tx_en) ^ $past(tx_err)));
    // R5
    tx_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(tx_en) && !$past(tx_err)) |-> (!hp_txctl && !rgm_txctl));
    // R6
    rx_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> rx_data == $past({rgm_rxd, hp_rxd}));
    // R7
    rx_dv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> rx_dv == $past(hp_rxctl));
    // R7
    rx_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> rx_err == ($past(hp_rxctl) ^ $past(rgm_rxctl)));
endmodule

bind rgmii_ddr_adapter rgmii_ddr_adapter_chk #(.NIB_W(NIB_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_data   (tx_data),
    .tx_en     (tx_en),
    .tx_err    (tx_err),
    .rgm_txd   (rgm_txd),
    .rgm_txctl (rgm_txctl),
    .rgm_rxd   (rgm_rxd),
    .rgm_rxctl (rgm_rxctl),
    .rx_data   (rx_data),
    .rx_dv     (rx_dv),
    .rx_err    (rx_err)
);

// File: tb/test_rgmii_ddr_adapter.sv
`timescale 1ns/1ps
module test_rgmii_ddr_adapter;
    localparam int NCYC = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_en = 1'b0;
    logic       tx_err = 1'b0;
    logic [3:0] rgm_txd, rgm_rxd;
    logic       rgm_txctl, rgm_rxctl;
    logic [7:0] rx_data;
    logic       rx_dv, rx_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] d;
        logic       en;
        logic       er;
    } stim_t;

    stim_t      q[$];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;   // 250 MHz

    // loopback wiring for R8
    assign rgm_rxd   = rgm_txd;
    assign rgm_rxctl = rgm_txctl;

    rgmii_ddr_adapter i_rgmii_ddr_adapter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_data   (tx_data),
        .tx_en     (tx_en),
        .tx_err    (tx_err),
        .rgm_txd   (rgm_txd),
        .rgm_txctl (rgm_txctl),
        .rgm_rxd   (rgm_rxd),
        .rgm_rxctl (rgm_rxctl),
        .rx_data   (rx_data),
        .rx_dv     (rx_dv),
        .rx_err    (rx_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    function automatic stim_t gen(input int i, input logic [15:0] rnd);
        stim_t s;
        if (i < 16) begin
            s.d  = (8'h01 << (i % 8)) ^ 8'h30;
            s.en = i[0];
            s.er = i[1];
        end else if (i < 32) begin
            s.d  = i[0] ? 8'hFF : 8'h00;
            s.en = 1'b1;
            s.er = 1'b0;
        end else if (i < 48) begin
            s.d  = 8'(i * 19);   // idle with data present (R9)
            s.en = 1'b0;
            s.er = 1'b0;
        end else if (i < NCYC) begin
            s.d  = rnd[7:0];
            s.en = rnd[8];
            s.er = rnd[11] & rnd[12];
        end else begin
            s.d  = 8'h00;
            s.en = 1'b0;
            s.er = 1'b0;
        end
        return s;
    endfunction

    initial begin
        stim_t ns, etx, erx;
        // R1: inputs active while reset is held
        tx_data = 8'hA5; tx_en = 1'b1; tx_err = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 rgm_txd", 32'(rgm_txd), 32'h0);
        check("R1 rgm_txctl", 32'(rgm_txctl), 32'h0);
        check("R1 rx_data", 32'(rx_data), 32'h0);
        check("R1 rx_dv", 32'(rx_dv), 32'h0);
        check("R1 rx_err", 32'(rx_err), 32'h0);
        #2;
        check("R1 rgm_txd low phase", 32'(rgm_txd), 32'h0);
        tx_data = 8'h00; tx_en = 1'b0; tx_err = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        ns.d = 8'h00; ns.en = 1'b0; ns.er = 1'b0;
        q.push_back(ns);
        q.push_back(ns);

        for (int i = 0; i < NCYC + 2; i++) begin
            @(posedge clk); #1;
            etx = q[q.size()-1];
            erx = q[q.size()-2];
            // high phase after the sampling edge: R2, R4
            check("R2 rgm_txd high phase", 32'(rgm_txd), 32'(etx.d[3:0]));
            check("R4 rgm_txctl high phase", 32'(rgm_txctl), 32'(etx.en));
            // inbound result one cycle after sampling: R6, R7, R8, R9
            if (erx.en) check("R6 R8 rx_data", 32'(rx_data), 32'(erx.d));
            else        check("R9 rx_data idle", 32'(rx_data), 32'(erx.d));
            check("R7 R8 rx_dv", 32'(rx_dv), 32'(erx.en));
            check("R7 R8 rx_err", 32'(rx_err), 32'(erx.er));
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ns = gen(i, lfsr);
            tx_data = ns.d; tx_en = ns.en; tx_err = ns.er;
            q.push_back(ns);
            #2;
            // low phase of the same cycle: R3, R5
            check("R3 rgm_txd low phase", 32'(rgm_txd), 32'(etx.d[7:4]));
            check("R5 rgm_txctl low phase", 32'(rgm_txctl), 32'(etx.en ^ etx.er));
            if (q.size() > 4) void'(q.pop_front());
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired at %0t: actual running expected finished", $time);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule